// File: doc/BRIEF.md
# Watermark-Driven SPI Master

This block is a register-mapped SPI master that clocks bytes out of a transmit FIFO on MOSI and captures the bytes returned on MISO into a receive FIFO. It runs in mode 0 only: SCLK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. Each SCLK half period lasts `CLK_DIV` system clocks. One of four active-low chip selects is driven for the whole exchange.

An exchange is set up by two 24-bit counts. The burst count is the total number of bytes clocked. The transmit count is the number of those bytes that come from the transmit FIFO. Once the transmit count is used up, zero bytes are sent. A transfer may run far past the FIFO depth. Software keeps it going by refilling and draining the FIFOs when the watermark status bits raise the interrupt. If the transmit FIFO runs dry while transmit bytes are still owed, the engine waits with SCLK idle.

Software uses a simple one-cycle register bus. A write takes effect at the clock edge. A read returns data combinationally, and a read of the receive data port pops one byte at that edge.

Top module: `spi_wm_master`

## Requirements
- R1: After reset all chip selects are high, SCLK is low and the interrupt is low. The status register (0x14) reads 0x10, because the empty transmit FIFO meets trigger level 0. The control register (0x08) and the FIFO status register (0x1C) read 0.
- R2: Writing the control register (0x08) with bit 31 set starts an exchange when none is running. Bits 1:0 of the same write select which chip select is held low for the whole exchange, and the other chip selects stay high. Bit 31 reads 1 while the exchange runs and returns to 0 by itself when it ends.
- R3: Bytes are sent MSB first in mode 0. MOSI is stable at every rising SCLK edge, MISO is sampled on the rising edge, and SCLK stays low while no chip select is active.
- R4: The first N bytes come from the transmit FIFO in push order, where N is the transmit count (0x34). The remaining bytes, up to the burst count (0x30), are 0x00. Transmit FIFO bytes are pushed by writes to 0x200 (bits 7:0).
- R5: Every byte clocked is pushed into the receive FIFO, and reads of 0x300 (bits 7:0) pop it in arrival order. A byte that arrives while the receive FIFO is full is dropped and sets status bit 8.
- R6: Status bit 12 sets when the burst count reaches zero, and this includes an exchange started with a burst count of 0.
- R7: Status bit 0 is raised while the receive fill level is nonzero and at or above the receive trigger level (0x18 bits 7:0). Status bit 4 is raised while the transmit fill level is at or below the transmit trigger level (0x18 bits 23:16).
- R8: Writing 1 to a status bit clears it. A level condition that still holds raises the bit again on the next cycle.
- R9: The interrupt output is high exactly when some status bit and its matching enable bit are both set. The enable register is at 0x10 and uses the same bit positions as the status register.
- R10: The FIFO status register (0x1C) gives the receive fill count in bits 7:0 and the transmit fill count in bits 23:16. Writing bit 15 or bit 31 of 0x18 empties the receive FIFO or the transmit FIFO respectively.
- R11: If the transmit FIFO is empty while transmit bytes are still owed, the engine pauses with SCLK idle and the chip select held. It resumes when bytes are pushed, so a transfer longer than the FIFO completes under interrupt-driven refill and drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The bench aims at these edges:
- **Shortfall of transmit bytes.** The burst count exceeds the transmit count, so zero padding must follow the FIFO bytes. A design that keeps popping would send stale or repeated data.
- **Long transfer.** A 300-byte transfer runs purely from watermark interrupts. An off-by-one in a watermark compare, or a level bit that does not re-raise after its clear, stalls the service loop or loses bytes.
- **Starved transmit FIFO.** A design that ignores the empty flag clocks garbage instead of pausing.
- **Receive overflow.** A design that overwrites on overflow shows a wrong fill count or a missing overflow flag.
- **Zero-length start.** A design that decrements before testing would run through 16M bytes instead of finishing at once.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
    localparam int A_CTL   = 'h008;
    localparam int A_EN    = 'h010;
    localparam int A_STAT  = 'h014;
    localparam int A_FCTL  = 'h018;
    localparam int A_FSTAT = 'h01C;
    localparam int A_BURST = 'h030;
    localparam int A_XMIT  = 'h034;
    localparam int A_TXD   = 'h200;
    localparam int A_RXD   = 'h300;
    localparam int CNT_W   = 24;

    // status index i lives at register bit 4*i: rx ready, tx request, overflow, done
    function automatic logic [31:0] spread(input logic [3:0] v);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) r[4*i] = v[i];
        return r;
    endfunction

    function automatic logic [3:0] gather(input logic [31:0] w);
        return {w[12], w[8], w[4], w[0]};
    endfunction
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end
endmodule

// File: rtl/spi_wm_shift.sv
module spi_wm_shift #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic          done;
        logic [2:0]    bits;
        logic [DW-1:0] div;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } sh_st_t;

    sh_st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (load) begin
                d.active = 1'b1;
                d.tx     = tx_byte;
                d.div    = '0;
                d.bits   = '0;
                d.sclk   = 1'b0;
            end
        end else if (q.div == DW'(DIV - 1)) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                d.tx   = {q.tx[6:0], 1'b0};
                d.bits = q.bits + 1'b1;
                if (q.bits == 3'd7) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.tx[7];
    assign busy    = q.active;
    assign done    = q.done;
    assign rx_byte = q.rx;
endmodule

// File: rtl/spi_wm_master.sv
module spi_wm_master
    import spi_wm_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int CLK_DIV    = 2,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [3:0]        spi_cs_n
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic             busy;
        logic             inflight;
        logic [1:0]       cs_sel;
        logic [3:0]       en;
        logic [3:0]       stat;
        logic [7:0]       rx_trig;
        logic [7:0]       tx_trig;
        logic [CNT_W-1:0] burst;
        logic [CNT_W-1:0] xmit;
    } ctl_st_t;

    ctl_st_t q, d;

    logic wr_en, rd_en;
    logic tx_push, tx_pop, tx_flush, tx_full, tx_empty;
    logic rx_pop, rx_flush, rx_full, rx_empty;
    logic [7:0] tx_dout, rx_dout, sh_tx, sh_rx;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic sh_load, sh_busy, sh_done, eng_done, xfer_busy;
    logic [3:0] clr, set, stat_now;

    assign wr_en    = bus_sel && bus_we;
    assign rd_en    = bus_sel && !bus_we;
    assign tx_push  = wr_en && (bus_addr == ADDR_W'(A_TXD));
    assign rx_pop   = rd_en && (bus_addr == ADDR_W'(A_RXD));
    assign tx_flush = wr_en && (bus_addr == ADDR_W'(A_FCTL)) && bus_wdata[31];
    assign rx_flush = wr_en && (bus_addr == ADDR_W'(A_FCTL)) && bus_wdata[15];
    assign sh_tx    = (q.xmit != '0) ? tx_dout : 8'h00;

    spi_wm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spi_wm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(sh_done), .din(sh_rx),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    spi_wm_shift #(.DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_byte(sh_tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx));

    always_comb begin
        d        = q;
        clr      = '0;
        tx_pop   = 1'b0;
        sh_load  = 1'b0;
        eng_done = 1'b0;

        if (wr_en) begin
            unique case (bus_addr)
                ADDR_W'(A_CTL): if (!q.busy) begin
                    d.cs_sel = bus_wdata[1:0];
                    d.busy   = bus_wdata[31];
                end
                ADDR_W'(A_EN):   d.en = gather(bus_wdata);
                ADDR_W'(A_STAT): clr  = gather(bus_wdata);
                ADDR_W'(A_FCTL): begin
                    d.rx_trig = bus_wdata[7:0];
                    d.tx_trig = bus_wdata[23:16];
                end
                ADDR_W'(A_BURST): if (!q.busy) d.burst = bus_wdata[CNT_W-1:0];
                ADDR_W'(A_XMIT):  if (!q.busy) d.xmit  = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end

        if (sh_done) begin
            d.inflight = 1'b0;
            d.burst    = q.burst - 1'b1;
        end

        if (q.busy && !q.inflight) begin
            if (q.burst == '0) begin
                d.busy   = 1'b0;
                eng_done = 1'b1;
            end else if (q.xmit == '0) begin
                sh_load    = 1'b1;
                d.inflight = 1'b1;
            end else if (!tx_empty) begin
                sh_load    = 1'b1;
                tx_pop     = 1'b1;
                d.inflight = 1'b1;
                d.xmit     = q.xmit - 1'b1;
            end
        end

        set[0] = (rx_cnt != '0) && (32'(rx_cnt) >= 32'(q.rx_trig));
        set[1] = 32'(tx_cnt) <= 32'(q.tx_trig);
        set[2] = sh_done && rx_full;
        set[3] = eng_done;
        d.stat = (q.stat & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(A_CTL):   bus_rdata = {q.busy, 29'b0, q.cs_sel};
            ADDR_W'(A_EN):    bus_rdata = spread(q.en);
            ADDR_W'(A_STAT):  bus_rdata = spread(q.stat);
            ADDR_W'(A_FCTL):  bus_rdata = {8'b0, q.tx_trig, 8'b0, q.rx_trig};
            ADDR_W'(A_FSTAT): bus_rdata = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
            ADDR_W'(A_BURST): bus_rdata = 32'(q.burst);
            ADDR_W'(A_XMIT):  bus_rdata = 32'(q.xmit);
            ADDR_W'(A_RXD):   bus_rdata = {24'b0, rx_dout};
            default:          bus_rdata = '0;
        endcase
    end

    assign xfer_busy = q.busy;
    assign stat_now  = q.stat;
    assign irq       = |(q.stat & q.en);
    assign spi_cs_n  = q.busy ? ~(4'b0001 << q.cs_sel) : 4'hF;
endmodule

// File: rtl/spi_wm_chk.sv
module spi_wm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       mosi,
    input logic [3:0] cs_n,
    input logic       busy,
    input logic [3:0] stat,
    input logic       rx_full,
    input logic       rx_push
);
    a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> stat[3]);

    a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> stat[2]);
endmodule

bind spi_wm_master spi_wm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .busy(xfer_busy), .stat(stat_now), .rx_full(rx_full), .rx_push(sh_done));

// File: tb/spi_wm_master_tb.sv
module spi_wm_master_tb;
    import spi_wm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    spi_wm_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] txb(input int k);
        return 8'((k * 13 + 7) & 255);
    endfunction

    // behavioural slave: queues of observed MOSI bytes, chip selects and expected RX bytes
    int sk = 0, sbit = 0;
    logic [7:0] ssh = '0, cur;
    logic [7:0] mosi_got[$];
    logic [3:0] cs_got[$];
    logic [7:0] exp_rx[$];

    assign cur = pat(sk);
    assign spi_miso = cur[3'(7 - sbit)];

    always @(posedge spi_sclk) begin
        ssh = {ssh[6:0], spi_mosi};
        if (sbit == 7) begin
            mosi_got.push_back(ssh);
            cs_got.push_back(spi_cs_n);
            exp_rx.push_back(pat(sk));
            sbit = 0;
            sk++;
        end else begin
            sbit++;
        end
    end

    // per-clock comparison of the pin-level rules
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(&spi_cs_n) || !spi_sclk, "R3 sclk idle when deselected", spi_sclk, 0);
            check($countones(~spi_cs_n) <= 1, "R2 single chip select", spi_cs_n, 4'hF);
        end
    end

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'(a); bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'(a);
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 30000) begin
            @(negedge clk);
            n++;
        end
        check(irq, req, irq, 1);
    endtask

    task automatic drain(inout int got);
        logic [31:0] v, b;
        rd(A_FSTAT, v);
        for (int i = 0; i < int'(v[7:0]); i++) begin
            rd(A_RXD, b);
            check(exp_rx.size() > 0 && b[7:0] == exp_rx[0], "R5 rx byte order", b[7:0],
                  exp_rx.size() > 0 ? exp_rx[0] : 0);
            if (exp_rx.size() > 0) void'(exp_rx.pop_front());
            got++;
        end
    endtask

    task automatic fill(inout int sent, input int total);
        logic [31:0] v;
        int free;
        rd(A_FSTAT, v);
        free = 128 - int'(v[23:16]);
        while (free > 0 && sent < total) begin
            wr(A_TXD, 32'(txb(sent)));
            sent++;
            free--;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int sent, got, n;
        bit fin;
        logic [7:0] sb [3];
        sb[0] = 8'hA5; sb[1] = 8'h3C; sb[2] = 8'h81;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 4'hF, "R1 cs idle", spi_cs_n, 4'hF);
        check(!spi_sclk, "R1 sclk low", spi_sclk, 0);
        check(!irq, "R1 irq low", irq, 0);
        rd(A_STAT, v);  check(v == 32'h10, "R1 status", v, 32'h10);
        rd(A_CTL, v);   check(v == 0, "R1 control", v, 0);
        rd(A_FSTAT, v); check(v == 0, "R1 fifo status", v, 0);

        // short transfer with zero padding: R2 R3 R4 R5 R6 R9
        mosi_got.delete(); cs_got.delete(); exp_rx.delete();
        wr(A_EN, 32'h1000);
        for (int i = 0; i < 3; i++) wr(A_TXD, 32'(sb[i]));
        wr(A_BURST, 5);
        wr(A_XMIT, 3);
        wr(A_CTL, 32'h8000_0002);
        rd(A_CTL, v); check(v[31], "R2 busy while running", v[31], 1);
        wait_irq("R9 irq on done");
        check(mosi_got.size() == 5, "R4 byte count", mosi_got.size(), 5);
        for (int i = 0; i < 5 && i < mosi_got.size(); i++) begin
            check(mosi_got[i] == ((i < 3) ? sb[i] : 8'h00), "R4 mosi data", mosi_got[i],
                  (i < 3) ? sb[i] : 8'h00);
            check(cs_got[i] == 4'b1011, "R2 chip select", cs_got[i], 4'b1011);
        end
        rd(A_CTL, v);  check(!v[31], "R2 busy self-clears", v[31], 0);
        rd(A_STAT, v); check(v[12], "R6 done flag", v[12], 1);
        rd(A_FSTAT, v); check(v[7:0] == 5, "R10 rx fill count", v[7:0], 5);
        got = 0;
        drain(got);
        check(got == 5, "R5 rx bytes", got, 5);
        wr(A_STAT, 32'h1000);
        @(negedge clk);
        check(!irq, "R8 R9 irq after clear", irq, 0);
        rd(A_STAT, v); check(!v[12], "R8 done cleared", v[12], 0);

        // zero-length start: R6
        mosi_got.delete();
        wr(A_BURST, 0);
        wr(A_CTL, 32'h8000_0000);
        wait_irq("R6 zero-length done");
        check(mosi_got.size() == 0, "R6 no bytes for zero burst", mosi_got.size(), 0);
        wr(A_STAT, 32'h1000);

        // level re-raise: R7 R8
        wr(A_FCTL, 32'h0000_0002);
        wr(A_BURST, 2);
        wr(A_XMIT, 0);
        wr(A_CTL, 32'h8000_0000);
        wait_irq("R6 done for level test");
        rd(A_STAT, v); check(v[0], "R7 rx ready at trigger", v[0], 1);
        wr(A_STAT, 32'h0000_0001);
        rd(A_STAT, v); check(v[0], "R8 level re-raises", v[0], 1);
        rd(A_RXD, v);
        check(v[7:0] == exp_rx[0], "R5 rx byte", v[7:0], exp_rx[0]);
        void'(exp_rx.pop_front());
        wr(A_STAT, 32'h0000_0001);
        rd(A_STAT, v); check(!v[0], "R7 rx ready below trigger", v[0], 0);
        wr(A_FCTL, 32'h0000_8000);
        exp_rx.delete();
        rd(A_FSTAT, v); check(v[7:0] == 0, "R10 rx flush", v[7:0], 0);
        wr(A_TXD, 1); wr(A_TXD, 2);
        wr(A_STAT, 32'h0000_0010);
        rd(A_STAT, v); check(!v[4], "R7 tx request above trigger", v[4], 0);
        rd(A_FSTAT, v); check(v[23:16] == 2, "R10 tx fill count", v[23:16], 2);
        wr(A_FCTL, 32'h8000_0000);
        rd(A_FSTAT, v); check(v[23:16] == 0, "R10 tx flush", v[23:16], 0);
        rd(A_STAT, v); check(v[4], "R7 tx request when empty", v[4], 1);
        wr(A_STAT, 32'h1111);

        // starved transmit FIFO pauses: R11
        mosi_got.delete(); exp_rx.delete();
        wr(A_BURST, 2);
        wr(A_XMIT, 2);
        wr(A_CTL, 32'h8000_0003);
        repeat (100) @(negedge clk);
        check(mosi_got.size() == 0, "R11 paused without data", mosi_got.size(), 0);
        check(spi_cs_n == 4'b0111, "R11 cs held while paused", spi_cs_n, 4'b0111);
        wr(A_TXD, 32'h5A); wr(A_TXD, 32'hC3);
        wait_irq("R11 resume and finish");
        check(mosi_got.size() == 2 && mosi_got[0] == 8'h5A && mosi_got[1] == 8'hC3,
              "R11 resumed bytes", mosi_got.size() > 1 ? {mosi_got[0], mosi_got[1]} : 0, 16'h5AC3);
        wr(A_FCTL, 32'h0000_8000);
        wr(A_STAT, 32'h1111);

        // long watermark-driven transfer: R7 R11
        mosi_got.delete(); cs_got.delete(); exp_rx.delete();
        sent = 0; got = 0; fin = 0; n = 0;
        wr(A_FCTL, 32'h8060_8060);
        fill(sent, 300);
        wr(A_BURST, 300);
        wr(A_XMIT, 300);
        wr(A_STAT, 32'h1111);
        wr(A_EN, 32'h1011);
        wr(A_CTL, 32'h8000_0001);
        while (!fin && n < 60000) begin
            @(negedge clk);
            n++;
            if (irq) begin
                rd(A_STAT, v);
                if (v[12]) fin = 1;
                else begin
                    if (v[0]) begin drain(got); wr(A_STAT, 32'h1); end
                    if (v[4]) begin
                        fill(sent, 300);
                        if (sent == 300) wr(A_EN, 32'h1001);
                        wr(A_STAT, 32'h10);
                    end
                end
            end
        end
        drain(got);
        check(fin, "R11 long transfer completes", fin, 1);
        check(got == 300, "R11 all rx bytes drained", got, 300);
        check(mosi_got.size() == 300, "R11 all bytes sent", mosi_got.size(), 300);
        for (int i = 0; i < mosi_got.size(); i++)
            if (mosi_got[i] != txb(i)) check(0, "R4 long mosi data", mosi_got[i], txb(i));
        check(cs_got.size() > 0 && cs_got[0] == 4'b1101, "R2 cs for long transfer",
              cs_got.size() > 0 ? cs_got[0] : 0, 4'b1101);
        wr(A_STAT, 32'h1111);

        // receive overflow: R5
        mosi_got.delete();
        wr(A_FCTL, 32'h8000_8000);
        wr(A_EN, 32'h1000);
        wr(A_BURST, 130);
        wr(A_XMIT, 0);
        wr(A_CTL, 32'h8000_0000);
        wait_irq("R6 done after overflow run");
        rd(A_FSTAT, v); check(v[7:0] == 128, "R5 rx fill capped", v[7:0], 128);
        rd(A_STAT, v);  check(v[8], "R5 overflow flag", v[8], 1);
        check(mosi_got.size() == 130 && mosi_got[129] == 8'h00, "R4 zero bytes",
              mosi_got.size(), 130);
        rd(A_RXD, v);
        check(exp_rx.size() > 0 && v[7:0] == exp_rx[0], "R5 oldest byte kept", v[7:0],
              exp_rx.size() > 0 ? exp_rx[0] : 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule